// File: doc/BRIEF.md
# Bus Data Parity Monitor

This block watches a 32-bit multiplexed PCI bus from the side and checks the parity of every data transfer. It never drives the bus. All bus lines are captured into registers on each rising clock edge first. Parity is then worked out locally over the captured address/data and byte-enable lines of each completed data phase. That result is compared with the PAR line that the bus carries one clock later.

The result appears as two registered outputs. `par_valid_o` pulses once for each data phase whose parity has arrived. `perr_o` pulses in the same cycle when the two parities differ. Two static inputs control checking. `chk_en_i` turns the comparison on or off. `state_mode_i` selects latched state acquisition (1) or pass-through timing acquisition (0), and checking exists only in state mode. Address phases are never checked.

Top module: `pci_par_mon`

## Requirements
- R1: Even parity is used. The expected PAR of a data phase is the XOR of `ad_i[31:0]` and `cbe_n_i[3:0]` in the cycle where `irdy_n_i` and `trdy_n_i` are both 0. The PAR of that phase is taken from `par_i` one cycle later. When the two agree, `par_valid_o` pulses and `perr_o` stays 0.
- R2: When the PAR carried for a completed data phase differs from the computed parity, `perr_o` is raised.
- R3: Let a data phase complete in the cycle sampled at rising edge k. Then `par_valid_o` and `perr_o` become 1 after edge k+2 and return to 0 after edge k+3, unless another phase follows directly.
- R4: An address phase is never checked, even if `irdy_n_i` and `trdy_n_i` are both 0 during it. An address phase is a cycle with `frame_n_i` = 0 whose previous cycle had `frame_n_i` = 1, and this includes a fast back-to-back start.
- R5: While `chk_en_i` = 0 in the PAR cycle, `perr_o` stays 0 whatever the parity, and `par_valid_o` still pulses.
- R6: While `state_mode_i` = 0 (timing mode) in the PAR cycle, both `par_valid_o` and `perr_o` stay 0.
- R7: Wait cycles, where `irdy_n_i` or `trdy_n_i` is 1, are not checked and produce no strobe.
- R8: Data phases that complete in consecutive cycles each give their own one-cycle strobe in consecutive cycles. Each strobe carries that phase's own mismatch result.
- R9: A synchronous active-low reset `rst_n` clears the capture pipeline and both outputs one edge after it is sampled low. A phase that is in flight across the reset is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Multiplexed address/data lines |
| cbe_n_i | input | 4 | Command / byte-enable lines (active low) |
| par_i | input | 1 | Parity line carried on the bus |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| chk_en_i | input | 1 | Parity check enable switch (1 = on) |
| state_mode_i | input | 1 | Acquisition mode (1 = state, 0 = timing) |
| par_valid_o | output | 1 | One-cycle strobe: parity of a data phase compared |
| perr_o | output | 1 | One-cycle data parity mismatch flag |

## Verification
Each stimulus pattern separates one rule of the block from a near miss.

- Single transfers with correct and inverted PAR separate a match from a mismatch and pin down the two-edge latency.
- Bursts with a single bad beat show that every strobe belongs to its own phase.
- Wait cycles carrying wrong PAR, and address phases with both ready lines low (including a fast back-to-back start), show that only completed data phases are compared.
- Bad parity with the enable off, in timing mode, and across a reset shows how each gate suppresses the flag or the strobe.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

   localparam int PCHK_AD_W_DEF = 32;

   typedef enum logic {
      ACQ_TIMING = 1'b0,
      ACQ_STATE  = 1'b1
   } acq_mode_e;

   typedef struct packed {
      logic frame_n;
      logic irdy_n;
      logic trdy_n;
      logic par;
      logic chk_en;
      logic state_mode;
   } bus_ctl_s;

   localparam bus_ctl_s BUS_CTL_IDLE = '{frame_n: 1'b1, irdy_n: 1'b1, trdy_n: 1'b1,
                                         par: 1'b0, chk_en: 1'b0, state_mode: ACQ_TIMING};

endpackage

// File: rtl/pchk_sampler.sv
module pchk_sampler
   import pchk_pkg::*;
#(
   parameter int AD_W = PCHK_AD_W_DEF,
   parameter int BE_W = AD_W / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AD_W-1:0] ad_i,
   input  logic [BE_W-1:0] cbe_n_i,
   input  bus_ctl_s        ctl_i,
   output logic [AD_W-1:0] s_ad_o,
   output logic [BE_W-1:0] s_be_o,
   output bus_ctl_s        s_ctl_o,
   output logic            s_frame_prev_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_ad_o         <= '0;
         s_be_o         <= '0;
         s_ctl_o        <= BUS_CTL_IDLE;
         s_frame_prev_o <= 1'b1;
      end else begin
         s_ad_o         <= ad_i;
         s_be_o         <= cbe_n_i;
         s_ctl_o        <= ctl_i;
         s_frame_prev_o <= s_ctl_o.frame_n;
      end
   end

endmodule

// File: rtl/pchk_parity_tree.sv
module pchk_parity_tree #(
   parameter int N    = 36,
   parameter bit FLAT = 1'b0
) (
   input  logic [N-1:0] vec_i,
   output logic         par_o
);

   localparam int LVLS   = (N > 1) ? $clog2(N) : 0;
   localparam int LEAVES = 1 << LVLS;

   if (N < 1) begin : g_bad_n
      $error("pchk_parity_tree: N must be at least 1");
   end

   if (FLAT) begin : g_flat
      assign par_o = ^vec_i;
   end else begin : g_tree
      for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
         logic [(LEAVES >> l)-1:0] v;
         if (l == 0) begin : g_leaf
            assign v = LEAVES'(vec_i);
         end else begin : g_red
            for (genvar i = 0; i < (LEAVES >> l); i++) begin : g_x
               assign v[i] = g_lvl[l-1].v[2*i] ^ g_lvl[l-1].v[2*i+1];
            end
         end
      end
      assign par_o = g_lvl[LVLS].v[0];
   end

endmodule

// File: rtl/pchk_phase_track.sv
module pchk_phase_track
   import pchk_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  bus_ctl_s s_ctl_i,
   input  logic     s_frame_prev_i,
   input  logic     calc_par_i,
   output logic     pend_valid_o,
   output logic     pend_par_o
);

   logic addr_phase;
   logic data_done;

   assign addr_phase = !s_ctl_i.frame_n && s_frame_prev_i;
   assign data_done  = !s_ctl_i.irdy_n && !s_ctl_i.trdy_n && !addr_phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid_o <= 1'b0;
         pend_par_o   <= 1'b0;
      end else begin
         pend_valid_o <= data_done;
         pend_par_o   <= calc_par_i;
      end
   end

   assert_addr_phase_skipped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_ctl_i.frame_n && s_frame_prev_i) |=> !pend_valid_o);

   assert_pending_needs_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid_o |-> $past(!s_ctl_i.irdy_n && !s_ctl_i.trdy_n));

endmodule

// File: rtl/pci_par_mon.sv
module pci_par_mon
   import pchk_pkg::*;
#(
   parameter int AD_W      = PCHK_AD_W_DEF,
   parameter bit FLAT_TREE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AD_W-1:0]   ad_i,
   input  logic [AD_W/8-1:0] cbe_n_i,
   input  logic              par_i,
   input  logic              frame_n_i,
   input  logic              irdy_n_i,
   input  logic              trdy_n_i,
   input  logic              chk_en_i,
   input  logic              state_mode_i,
   output logic              par_valid_o,
   output logic              perr_o
);

   localparam int BE_W  = AD_W / 8;
   localparam int PAR_N = AD_W + BE_W;

   if ((AD_W % 8) != 0 || AD_W < 8) begin : g_bad_w
      $error("pci_par_mon: AD_W must be a positive multiple of 8");
   end

   bus_ctl_s        ctl_in;
   bus_ctl_s        s_ctl;
   logic [AD_W-1:0] s_ad;
   logic [BE_W-1:0] s_be;
   logic            s_frame_prev;
   logic            calc_par;
   logic            pend_valid;
   logic            pend_par;
   logic            valid_q;
   logic            perr_q;

   assign ctl_in = '{frame_n: frame_n_i, irdy_n: irdy_n_i, trdy_n: trdy_n_i,
                     par: par_i, chk_en: chk_en_i, state_mode: state_mode_i};

   pchk_sampler #(.AD_W(AD_W), .BE_W(BE_W)) u_smp (
      .clk            (clk),
      .rst_n          (rst_n),
      .ad_i           (ad_i),
      .cbe_n_i        (cbe_n_i),
      .ctl_i          (ctl_in),
      .s_ad_o         (s_ad),
      .s_be_o         (s_be),
      .s_ctl_o        (s_ctl),
      .s_frame_prev_o (s_frame_prev)
   );

   pchk_parity_tree #(.N(PAR_N), .FLAT(FLAT_TREE)) u_tree (
      .vec_i (({s_be, s_ad})),
      .par_o (calc_par)
   );

   pchk_phase_track u_trk (
      .clk            (clk),
      .rst_n          (rst_n),
      .s_ctl_i        (s_ctl),
      .s_frame_prev_i (s_frame_prev),
      .calc_par_i     (calc_par),
      .pend_valid_o   (pend_valid),
      .pend_par_o     (pend_par)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         perr_q  <= 1'b0;
      end else begin
         valid_q <= pend_valid && (s_ctl.state_mode == ACQ_STATE);
         perr_q  <= pend_valid && (s_ctl.state_mode == ACQ_STATE) && s_ctl.chk_en
                    && (pend_par != s_ctl.par);
      end
   end

   assign par_valid_o = valid_q;
   assign perr_o      = perr_q;

   assert_flag_only_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |-> par_valid_o);

   assert_mismatch_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && s_ctl.state_mode && s_ctl.chk_en && (pend_par != s_ctl.par)) |=> perr_o);

   assert_enable_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ctl.chk_en |=> !perr_o);

   assert_timing_mode_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !s_ctl.state_mode |=> !(perr_o || par_valid_o));

   assert_strobe_per_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_valid && s_ctl.state_mode) |=> par_valid_o);

   assert_reset_clears_R9: assert property (@(posedge clk)
      !rst_n |=> (!perr_o && !par_valid_o));

endmodule

// File: tb/sim_pci_par_mon.sv
`timescale 1ns/1ps
module sim_pci_par_mon;

   localparam int AD_W = 32;
   localparam int BE_W = AD_W / 8;
   localparam int HN   = 1024;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AD_W-1:0] ad = '0;
   logic [BE_W-1:0] cbe_n = '0;
   logic            par = 1'b0;
   logic            frame_n = 1'b1;
   logic            irdy_n = 1'b1;
   logic            trdy_n = 1'b1;
   logic            chk_en = 1'b1;
   logic            state_mode = 1'b1;
   logic            par_valid;
   logic            perr;

   always #2.5 clk = ~clk;

   pci_par_mon u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .ad_i         (ad),
      .cbe_n_i      (cbe_n),
      .par_i        (par),
      .frame_n_i    (frame_n),
      .irdy_n_i     (irdy_n),
      .trdy_n_i     (trdy_n),
      .chk_en_i     (chk_en),
      .state_mode_i (state_mode),
      .par_valid_o  (par_valid),
      .perr_o       (perr)
   );

   logic [AD_W-1:0] h_ad [HN];
   logic [BE_W-1:0] h_be [HN];
   logic h_par [HN];
   logic h_fr  [HN];
   logic h_ir  [HN];
   logic h_tr  [HN];
   logic h_en  [HN];
   logic h_md  [HN];
   logic h_rs  [HN];

   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string tag = "R9";
   logic  sw_en = 1'b1;
   logic  sw_md = 1'b1;
   logic  sw_rs = 1'b0;

   function automatic logic evp(input logic [AD_W-1:0] a, input logic [BE_W-1:0] b);
      return ^{b, a};
   endfunction

   function automatic logic fr_eff(input int c);
      if (c < 0) return 1'b1;
      return h_rs[c] ? h_fr[c] : 1'b1;
   endfunction

   task automatic step(input logic [AD_W-1:0] a, input logic [BE_W-1:0] b,
                       input logic p, input logic fr, input logic ir, input logic tr);
      logic exp_v;
      logic exp_e;
      @(negedge clk);
      exp_v = 1'b0;
      exp_e = 1'b0;
      if (cyc >= 3) begin
         int  k;
         logic ok;
         logic dn;
         k  = cyc - 3;
         ok = h_rs[k] && h_rs[k+1] && h_rs[k+2];
         dn = !h_ir[k] && !h_tr[k] && !(!fr_eff(k) && fr_eff(k-1));
         if (ok && dn && h_md[k+1]) begin
            exp_v = 1'b1;
            exp_e = h_en[k+1] && (h_par[k+1] != evp(h_ad[k], h_be[k]));
         end
      end
      checks++;
      if (par_valid !== exp_v) begin
         errors++;
         $display("FAIL %s cycle %0d par_valid_o actual %b expected %b", tag, cyc, par_valid, exp_v);
      end
      checks++;
      if (perr !== exp_e) begin
         errors++;
         $display("FAIL %s cycle %0d perr_o actual %b expected %b", tag, cyc, perr, exp_e);
      end
      ad = a; cbe_n = b; par = p; frame_n = fr; irdy_n = ir; trdy_n = tr;
      chk_en = sw_en; state_mode = sw_md; rst_n = !sw_rs;
      h_ad[cyc] = a; h_be[cyc] = b; h_par[cyc] = p; h_fr[cyc] = fr;
      h_ir[cyc] = ir; h_tr[cyc] = tr; h_en[cyc] = sw_en; h_md[cyc] = sw_md;
      h_rs[cyc] = !sw_rs;
      cyc++;
   endtask

   task automatic idle(input int n, input logic p);
      for (int i = 0; i < n; i++) step('0, '0, p, 1'b1, 1'b1, 1'b1);
   endtask

   // one address phase followed by one data phase; bad inverts the carried PAR
   task automatic single_xfer(input logic [AD_W-1:0] d, input logic [BE_W-1:0] b, input bit bad);
      step(32'h0000_1000, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1);
      step(d, b, evp(32'h0000_1000, 4'h7), 1'b1, 1'b0, 1'b0);
      step('0, '0, evp(d, b) ^ bad, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic t_reset_start;
      tag = "R9";
      sw_rs = 1'b1;
      idle(3, 1'b0);
      sw_rs = 1'b0;
      idle(3, 1'b0);
   endtask

   task automatic t_good;
      tag = "R1";
      single_xfer(32'hA5A5_0F0F, 4'h0, 1'b0);
      single_xfer(32'hFFFF_FFFF, 4'hE, 1'b0);
      single_xfer(32'h0000_0001, 4'h3, 1'b0);
      idle(4, 1'b0);
   endtask

   task automatic t_bad;
      tag = "R2";
      single_xfer(32'h1234_5678, 4'h0, 1'b1);
      tag = "R3";
      idle(4, 1'b0);
      tag = "R2";
      single_xfer(32'h0000_0000, 4'hF, 1'b1);
      tag = "R3";
      idle(4, 1'b1);
   endtask

   task automatic t_wait;
      tag = "R7";
      step(32'h0000_2000, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1);
      step(32'h1111_0000, 4'h0, evp(32'h0000_2000, 4'h6), 1'b0, 1'b1, 1'b0);
      step(32'h2222_0000, 4'h0, ~evp(32'h1111_0000, 4'h0), 1'b0, 1'b0, 1'b1);
      step(32'h3333_0000, 4'h0, ~evp(32'h2222_0000, 4'h0), 1'b1, 1'b0, 1'b0);
      step('0, '0, evp(32'h3333_0000, 4'h0), 1'b1, 1'b1, 1'b1);
      idle(4, 1'b1);
   endtask

   task automatic t_burst;
      logic [AD_W-1:0] d [4];
      d[0] = 32'h0102_0304; d[1] = 32'hDEAD_BEEF; d[2] = 32'h8000_0000; d[3] = 32'h7FFF_FFFF;
      tag = "R8";
      step(32'h0000_3000, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1);
      step(d[0], 4'h0, evp(32'h0000_3000, 4'h7), 1'b0, 1'b0, 1'b0);
      step(d[1], 4'h1, evp(d[0], 4'h0), 1'b0, 1'b0, 1'b0);
      step(d[2], 4'h2, ~evp(d[1], 4'h1), 1'b0, 1'b0, 1'b0);
      step(d[3], 4'h3, evp(d[2], 4'h2), 1'b1, 1'b0, 1'b0);
      step('0, '0, ~evp(d[3], 4'h3), 1'b1, 1'b1, 1'b1);
      idle(4, 1'b0);
   endtask

   task automatic t_addr;
      tag = "R4";
      step(32'h0000_4000, 4'h7, 1'b0, 1'b0, 1'b0, 1'b0);
      step('0, '0, ~evp(32'h0000_4000, 4'h7), 1'b1, 1'b1, 1'b1);
      idle(4, 1'b0);
      step(32'h0000_5000, 4'h6, 1'b0, 1'b0, 1'b1, 1'b1);
      step(32'hCAFE_0001, 4'h0, evp(32'h0000_5000, 4'h6), 1'b1, 1'b0, 1'b0);
      step(32'h0000_6000, 4'h7, evp(32'hCAFE_0001, 4'h0), 1'b0, 1'b0, 1'b0);
      step('0, '0, ~evp(32'h0000_6000, 4'h7), 1'b1, 1'b1, 1'b1);
      idle(4, 1'b0);
   endtask

   task automatic t_enable_off;
      tag = "R5";
      sw_en = 1'b0;
      idle(2, 1'b0);
      single_xfer(32'h5555_AAAA, 4'h9, 1'b1);
      idle(4, 1'b0);
      sw_en = 1'b1;
      idle(2, 1'b0);
   endtask

   task automatic t_timing_mode;
      tag = "R6";
      sw_md = 1'b0;
      idle(2, 1'b0);
      single_xfer(32'h0F0F_F0F0, 4'h5, 1'b1);
      single_xfer(32'h0000_00FF, 4'h0, 1'b0);
      idle(4, 1'b0);
      sw_md = 1'b1;
      idle(2, 1'b0);
   endtask

   task automatic t_reset_mid;
      tag = "R9";
      step(32'h0000_7000, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1);
      step(32'h9999_9999, 4'h0, evp(32'h0000_7000, 4'h7), 1'b1, 1'b0, 1'b0);
      sw_rs = 1'b1;
      step('0, '0, ~evp(32'h9999_9999, 4'h0), 1'b1, 1'b1, 1'b1);
      idle(1, 1'b0);
      sw_rs = 1'b0;
      idle(5, 1'b0);
   endtask

   initial begin
      t_reset_start();
      t_good();
      t_bad();
      t_wait();
      t_burst();
      t_addr();
      t_enable_off();
      t_timing_mode();
      t_reset_mid();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog timeout at cycle %0d actual running expected done", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule